// File: doc/BRIEF.md
# Backdoor Key Verification Unit

This block carries out the security-unlock command of a nonvolatile-memory command controller. Software first sets a parameter index register and then writes 16-bit words into an indexed parameter file. Entry 0 holds the command word, which the surrounding controller decodes, so this unit does not store it. Entries 1 to 4 hold the four key words. Software then pulses `launch`, which models clearing the command-complete flag. The unit checks the launch conditions. If they hold, it compares the supplied key words one per clock against a stored comparison key and either releases device security or records an access error.

A comparison that fails locks the command out. From then on, every later launch aborts with an access error, even when the key is correct and the enable field is valid. Only a reset clears the lockout. The access error flag is sticky. Software clears it by writing 1 through `err_clr`. All pins are plain control and status levels or strobes. No data stream crosses the boundary, so no pin needs a valid/ready handshake or back-pressure.

Top module: `bdkey_verify_unit`

## Requirements
- R1: After reset, `cmd_idle` is 1, `acc_err` is 0, `secured` is 1 and the lockout is clear.
- R2: A `launch` pulse is acted on only when `cmd_idle` is 1 and `acc_err` is 0. A pulse that arrives while busy or while `acc_err` is set has no effect on any output.
- R3: If `key_en` is not binary 10 at an accepted launch, `acc_err` is 1 from the next cycle, `cmd_idle` stays 1 and `secured` is unchanged.
- R4: If the parameter index register is not equal to NUM_KEYS (binary 100 with defaults) at an accepted launch, the command aborts in the same way as R3.
- R5: Key word i is taken from parameter entry i+1 and compared with `ref_key[i*KEY_W +: KEY_W]`. Word 0 sits at the lowest bits, which is the lowest address. When all words match, `secured` falls at completion.
- R6: After a launch passes its checks, `cmd_idle` is 0 from the next cycle for exactly NUM_KEYS+1 cycles, and then returns to 1.
- R7: If any key word differs, completion sets `acc_err`, sets the lockout and leaves `secured` unchanged.
- R8: While the lockout is set, every accepted launch aborts with `acc_err` set and `cmd_idle` staying 1, whatever the key and enable field are.
- R9: `prot_viol` and both bits of `mgn_flags` are always 0.
- R10: `acc_err` holds until `err_clr` is 1. When an error is raised in the same cycle as `err_clr`, the flag is set.
- R11: Writes to the index register and to the parameter file are ignored while `cmd_idle` is 0.
- R12: Once `secured` has fallen, it stays 0 until reset, including after a later mismatch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| idx_we | input | 1 | Write strobe for the parameter index register |
| idx_wdata | input | IDX_W | New parameter index value |
| data_we | input | 1 | Write strobe for the parameter entry at the current index |
| data_wdata | input | KEY_W | Parameter word to write |
| launch | input | 1 | Launch strobe (clearing of the command-complete flag) |
| err_clr | input | 1 | Write-1-to-clear for the access error flag |
| key_en | input | 2 | Key-enable field; binary 10 permits the command |
| ref_key | input | NUM_KEYS*KEY_W | Stored comparison key, word 0 in the lowest bits |
| cmd_idle | output | 1 | Command-complete flag |
| acc_err | output | 1 | Access error flag |
| prot_viol | output | 1 | Protection-violation flag, always 0 here |
| mgn_flags | output | 2 | Margin/verify status flags, always 0 here |
| secured | output | 1 | 1 while device security is active |

## Verification
The bench builds the unit with its defaults: 16-bit key words, four of them, and a 3-bit index. With these values the single legal index of 4 sits among seven wrong ones, and the bench reaches these by loading the key at entries 1 to 4 and then rewriting the index. Four words are enough to show that the comparison order matters: the same words loaded in reverse order must fail. The busy window of five cycles is short enough for the bench to fire strobes and register writes inside it. Distinct word values place each word in its own lane of `ref_key`, so a swapped lane or an off-by-one entry map shows up as a wrong unlock result.

// File: rtl/bdk_pkg.sv
package bdk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMP  = 2'd1,
    ST_DONE = 2'd2
  } bdk_state_e;
endpackage

// File: rtl/bdk_param_file.sv
// Index register plus the key-word entries 1..NUM_KEYS of the parameter file.
module bdk_param_file #(
  parameter int KEY_W    = 16,
  parameter int NUM_KEYS = 4,
  parameter int IDX_W    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_allow,
  input  logic                      idx_we,
  input  logic [IDX_W-1:0]          idx_wdata,
  input  logic                      data_we,
  input  logic [KEY_W-1:0]          data_wdata,
  output logic [IDX_W-1:0]          idx_q,
  output logic [NUM_KEYS*KEY_W-1:0] keys_flat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  idx_q <= '0;
    else if (wr_allow && idx_we) idx_q <= idx_wdata;
  end

  // Entry 0 (command word) is decoded by the surrounding controller.
  for (genvar i = 0; i < NUM_KEYS; i++) begin : g_entry
    localparam logic [IDX_W-1:0] ENTRY = IDX_W'(i + 1);
    logic [KEY_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q <= '0;
      else if (wr_allow && data_we && idx_q == ENTRY)
        word_q <= data_wdata;
    end
    assign keys_flat[i*KEY_W +: KEY_W] = word_q;
  end
endmodule

// File: rtl/bdk_launch_gate.sv
// Launch qualification: decides between ignore, abort and start.
module bdk_launch_gate #(
  parameter int         NUM_KEYS = 4,
  parameter int         IDX_W    = 3,
  parameter logic [1:0] EN_CODE  = 2'b10
) (
  input  logic             launch,
  input  logic             cmd_idle,
  input  logic             err_flag,
  input  logic             locked,
  input  logic [1:0]       key_en,
  input  logic [IDX_W-1:0] idx,
  output logic             abort,
  output logic             start
);
  localparam logic [IDX_W-1:0] REQ_IDX = IDX_W'(NUM_KEYS);

  logic accept;
  logic bad;

  always_comb begin
    accept = launch && cmd_idle && !err_flag;
    bad    = locked || (key_en != EN_CODE) || (idx != REQ_IDX);
    abort  = accept && bad;
    start  = accept && !bad;
  end
endmodule

// File: rtl/bdk_key_compare.sv
// Serial key comparator: one word per clock, then one completion cycle.
module bdk_key_compare import bdk_pkg::*; #(
  parameter int KEY_W    = 16,
  parameter int NUM_KEYS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [NUM_KEYS*KEY_W-1:0] keys_flat,
  input  logic [NUM_KEYS*KEY_W-1:0] ref_flat,
  output logic                      done,
  output logic                      mismatch
);
  localparam int CNT_W = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_KEYS - 1);

  bdk_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             mism_q;
  logic [KEY_W-1:0] cur_key;
  logic [KEY_W-1:0] cur_ref;

  always_comb begin
    cur_key = keys_flat[int'(cnt_q)*KEY_W +: KEY_W];
    cur_ref = ref_flat[int'(cnt_q)*KEY_W +: KEY_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      mism_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_CMP;
          cnt_q   <= '0;
          mism_q  <= 1'b0;
        end
        ST_CMP: begin
          mism_q <= mism_q | (cur_key != cur_ref);
          if (cnt_q == LAST) state_q <= ST_DONE;
          else               cnt_q   <= cnt_q + 1'b1;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done     = (state_q == ST_DONE);
  assign mismatch = mism_q;
endmodule

// File: rtl/bdkey_verify_unit.sv
module bdkey_verify_unit #(
  parameter int         KEY_W    = 16,
  parameter int         NUM_KEYS = 4,
  parameter int         IDX_W    = 3,
  parameter logic [1:0] EN_CODE  = 2'b10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      idx_we,
  input  logic [IDX_W-1:0]          idx_wdata,
  input  logic                      data_we,
  input  logic [KEY_W-1:0]          data_wdata,
  input  logic                      launch,
  input  logic                      err_clr,
  input  logic [1:0]                key_en,
  input  logic [NUM_KEYS*KEY_W-1:0] ref_key,
  output logic                      cmd_idle,
  output logic                      acc_err,
  output logic                      prot_viol,
  output logic [1:0]                mgn_flags,
  output logic                      secured
);
  logic [IDX_W-1:0]          idx_q;
  logic [NUM_KEYS*KEY_W-1:0] keys_flat;
  logic                      abort;
  logic                      start;
  logic                      done;
  logic                      mismatch;
  logic                      idle_q;
  logic                      err_q;
  logic                      sec_q;
  logic                      lock_q;

  bdk_param_file #(.KEY_W(KEY_W), .NUM_KEYS(NUM_KEYS), .IDX_W(IDX_W)) u_param (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_allow   (idle_q),
    .idx_we     (idx_we),
    .idx_wdata  (idx_wdata),
    .data_we    (data_we),
    .data_wdata (data_wdata),
    .idx_q      (idx_q),
    .keys_flat  (keys_flat)
  );

  bdk_launch_gate #(.NUM_KEYS(NUM_KEYS), .IDX_W(IDX_W), .EN_CODE(EN_CODE)) u_gate (
    .launch   (launch),
    .cmd_idle (idle_q),
    .err_flag (err_q),
    .locked   (lock_q),
    .key_en   (key_en),
    .idx      (idx_q),
    .abort    (abort),
    .start    (start)
  );

  bdk_key_compare #(.KEY_W(KEY_W), .NUM_KEYS(NUM_KEYS)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .keys_flat (keys_flat),
    .ref_flat  (ref_key),
    .done      (done),
    .mismatch  (mismatch)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= 1'b1;
      err_q  <= 1'b0;
      sec_q  <= 1'b1;
      lock_q <= 1'b0;
    end else begin
      if (start)     idle_q <= 1'b0;
      else if (done) idle_q <= 1'b1;
      err_q <= (err_q & ~err_clr) | abort | (done & mismatch);
      if (done && mismatch)  lock_q <= 1'b1;
      if (done && !mismatch) sec_q  <= 1'b0;
    end
  end

  assign cmd_idle  = idle_q;
  assign acc_err   = err_q;
  assign secured   = sec_q;
  assign prot_viol = 1'b0;
  assign mgn_flags = 2'b00;
endmodule

// File: rtl/bdk_checker.sv
module bdk_checker #(
  parameter int         NUM_KEYS = 4,
  parameter int         IDX_W    = 3,
  parameter logic [1:0] EN_CODE  = 2'b10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             launch,
  input logic             err_clr,
  input logic [1:0]       key_en,
  input logic [IDX_W-1:0] idx_q,
  input logic             lock_q,
  input logic             cmd_idle,
  input logic             acc_err,
  input logic             prot_viol,
  input logic [1:0]       mgn_flags,
  input logic             secured
);
  logic [7:0] busy_cnt;
  logic       acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy_cnt <= '0;
    else if (!cmd_idle) busy_cnt <= busy_cnt + 1'b1;
    else               busy_cnt <= '0;
  end

  assign acc = launch && cmd_idle && !acc_err;

  p_launch_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && cmd_idle && acc_err) |=> cmd_idle);

  p_bad_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && key_en != EN_CODE) |=> (acc_err && cmd_idle));

  p_bad_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && idx_q != IDX_W'(NUM_KEYS)) |=> (acc_err && cmd_idle));

  p_release_at_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(secured) |-> $rose(cmd_idle));

  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_idle) |-> (busy_cnt == 8'(NUM_KEYS + 1)));

  p_busy_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= 8'(NUM_KEYS + 1));

  p_lock_sets_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> (acc_err && $rose(cmd_idle) && $stable(secured)));

  p_lock_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && lock_q) |=> (acc_err && cmd_idle));

  p_flags_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!prot_viol && mgn_flags == 2'b00));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_err && !err_clr) |=> acc_err);

  p_release_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !secured |=> !secured);
endmodule

bind bdkey_verify_unit bdk_checker #(
  .NUM_KEYS (NUM_KEYS),
  .IDX_W    (IDX_W),
  .EN_CODE  (EN_CODE)
) u_bdk_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .launch    (launch),
  .err_clr   (err_clr),
  .key_en    (key_en),
  .idx_q     (idx_q),
  .lock_q    (lock_q),
  .cmd_idle  (cmd_idle),
  .acc_err   (acc_err),
  .prot_viol (prot_viol),
  .mgn_flags (mgn_flags),
  .secured   (secured)
);

// File: tb/test_bdkey_verify_unit.sv
module test_bdkey_verify_unit;
  localparam int CLK_PERIOD = 10;
  localparam int KEY_W = 16;
  localparam int NUM_KEYS = 4;
  localparam int IDX_W = 3;

  logic                      clk = 1'b0;
  logic                      rst_n = 1'b0;
  logic                      idx_we = 1'b0;
  logic [IDX_W-1:0]          idx_wdata = '0;
  logic                      data_we = 1'b0;
  logic [KEY_W-1:0]          data_wdata = '0;
  logic                      launch = 1'b0;
  logic                      err_clr = 1'b0;
  logic [1:0]                key_en = 2'b10;
  logic [NUM_KEYS*KEY_W-1:0] ref_key;
  logic                      cmd_idle;
  logic                      acc_err;
  logic                      prot_viol;
  logic [1:0]                mgn_flags;
  logic                      secured;

  int n_tests = 0;
  int n_fail  = 0;

  // Reference model state
  bit             m_idle, m_err, m_sec, m_lock, m_mis;
  int             m_busy;
  int             m_idx;
  bit [KEY_W-1:0] m_entry [NUM_KEYS+1];

  bit [KEY_W-1:0] good [NUM_KEYS];

  always #(CLK_PERIOD/2) clk = ~clk;

  bdkey_verify_unit #(.KEY_W(KEY_W), .NUM_KEYS(NUM_KEYS), .IDX_W(IDX_W)) i_bdkey_verify_unit (
    .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .idx_wdata(idx_wdata),
    .data_we(data_we), .data_wdata(data_wdata), .launch(launch),
    .err_clr(err_clr), .key_en(key_en), .ref_key(ref_key),
    .cmd_idle(cmd_idle), .acc_err(acc_err), .prot_viol(prot_viol),
    .mgn_flags(mgn_flags), .secured(secured)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model, one update per rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idle = 1; m_err = 0; m_sec = 1; m_lock = 0; m_mis = 0;
      m_busy = 0; m_idx = 0;
      for (int k = 0; k <= NUM_KEYS; k++) m_entry[k] = '0;
    end else begin
      bit was_idle;
      bit n_err;
      was_idle = m_idle;
      n_err = m_err & ~err_clr;
      if (m_busy > 0) begin
        m_busy--;
        if (m_busy == 0) begin
          m_idle = 1;
          if (m_mis) begin n_err = 1; m_lock = 1; end
          else m_sec = 0;
        end
      end else if (launch && m_idle && !m_err) begin
        if (m_lock || key_en != 2'b10 || m_idx != NUM_KEYS) n_err = 1;
        else begin
          m_mis = 0;
          for (int k = 0; k < NUM_KEYS; k++)
            if (m_entry[k+1] != ref_key[k*KEY_W +: KEY_W]) m_mis = 1;
          m_busy = NUM_KEYS + 1;
          m_idle = 0;
        end
      end
      if (was_idle) begin
        if (data_we && m_idx >= 1 && m_idx <= NUM_KEYS) m_entry[m_idx] = data_wdata;
        if (idx_we) m_idx = int'(idx_wdata);
      end
      m_err = n_err;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    check(cmd_idle === m_idle, "R6 cmd_idle", 32'(cmd_idle), 32'(m_idle));
    check(acc_err === m_err, "R10 acc_err", 32'(acc_err), 32'(m_err));
    check(secured === m_sec, "R5 secured", 32'(secured), 32'(m_sec));
    check(prot_viol === 1'b0 && mgn_flags === 2'b00, "R9 flags",
          {29'd0, prot_viol, mgn_flags}, 32'd0);
  end

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic clear_strobes();
    idx_we = 0; data_we = 0; launch = 0; err_clr = 0;
  endtask

  task automatic set_idx(input int v);
    idx_we = 1; idx_wdata = IDX_W'(v); step(1); clear_strobes();
  endtask

  task automatic put_word(input int entry, input logic [KEY_W-1:0] w);
    idx_we = 1; idx_wdata = IDX_W'(entry); step(1); clear_strobes();
    data_we = 1; data_wdata = w; step(1); clear_strobes();
  endtask

  task automatic load_key(input bit reversed);
    for (int k = 0; k < NUM_KEYS; k++)
      put_word(k + 1, reversed ? good[NUM_KEYS-1-k] : good[k]);
  endtask

  task automatic fire();
    launch = 1; step(1); clear_strobes();
  endtask

  task automatic clear_err();
    err_clr = 1; step(1); clear_strobes();
  endtask

  task automatic do_reset();
    rst_n = 0; step(2); rst_n = 1; step(1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL R6 watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    good[0] = 16'h7B90; good[1] = 16'h0F1E; good[2] = 16'hA5C3; good[3] = 16'h4D21;
    ref_key = {good[3], good[2], good[1], good[0]};
    clear_strobes();
    step(2);
    check(cmd_idle && !acc_err && secured, "R1 reset state",
          {29'd0, cmd_idle, acc_err, secured}, 32'h5);
    rst_n = 1; step(1);

    load_key(0);
    // R3: wrong enable encoding aborts
    key_en = 2'b01; fire(); step(1);
    check(acc_err === 1'b1 && cmd_idle === 1'b1, "R3 bad enable", {30'd0, acc_err, cmd_idle}, 32'h3);
    key_en = 2'b11; clear_err(); fire(); step(1);
    check(acc_err === 1'b1 && secured === 1'b1, "R3 enable 11", 32'(acc_err), 32'h1);
    key_en = 2'b10;
    // R2: launch while error is pending is ignored
    fire();
    check(cmd_idle === 1'b1, "R2 launch while error", 32'(cmd_idle), 32'h1);
    clear_err();

    // R4: index not equal to NUM_KEYS
    set_idx(3); fire(); step(1);
    check(acc_err === 1'b1 && cmd_idle === 1'b1, "R4 index 3", {30'd0, acc_err, cmd_idle}, 32'h3);
    clear_err(); set_idx(0); fire(); step(1);
    check(acc_err === 1'b1, "R4 index 0", 32'(acc_err), 32'h1);
    clear_err(); set_idx(4);

    // R5/R6: correct key, with writes and launches fired into the busy window (R11, R2)
    fire();
    check(cmd_idle === 1'b0, "R6 busy after launch", 32'(cmd_idle), 32'h0);
    idx_we = 1; idx_wdata = 3'd2; step(1); clear_strobes();
    data_we = 1; data_wdata = 16'hDEAD; launch = 1; step(1); clear_strobes();
    step(NUM_KEYS - 2);
    check(cmd_idle === 1'b0, "R6 still busy", 32'(cmd_idle), 32'h0);
    step(1);
    check(cmd_idle === 1'b1 && secured === 1'b0 && acc_err === 1'b0, "R5 release",
          {29'd0, cmd_idle, secured, acc_err}, 32'h4);
    // R11: index is still 4 and the key untouched, so a new launch runs and matches
    fire();
    check(cmd_idle === 1'b0, "R11 index kept", 32'(cmd_idle), 32'h0);
    step(NUM_KEYS + 1);
    check(acc_err === 1'b0, "R11 key kept", 32'(acc_err), 32'h0);
    // R12: later mismatch leaves security released
    put_word(2, 16'h1234); set_idx(4); fire(); step(NUM_KEYS + 2);
    check(secured === 1'b0 && acc_err === 1'b1, "R12 release sticky", {30'd0, secured, acc_err}, 32'h1);

    // R7: key loaded in reverse order fails
    do_reset();
    check(secured === 1'b1 && acc_err === 1'b0, "R1 after reset", {30'd0, secured, acc_err}, 32'h2);
    load_key(1); fire(); step(NUM_KEYS + 2);
    check(acc_err === 1'b1 && secured === 1'b1, "R7 reverse order", {30'd0, acc_err, secured}, 32'h3);
    // R8: lockout blocks a correct key
    clear_err(); load_key(0); fire(); step(1);
    check(acc_err === 1'b1 && cmd_idle === 1'b1 && secured === 1'b1, "R8 lockout",
          {29'd0, acc_err, cmd_idle, secured}, 32'h7);
    // R10: set wins over a simultaneous clear
    clear_err();
    launch = 1; err_clr = 1; step(1); clear_strobes(); step(1);
    check(acc_err === 1'b1, "R10 set beats clear", 32'(acc_err), 32'h1);
    step(3);
    check(acc_err === 1'b1, "R10 sticky", 32'(acc_err), 32'h1);
    clear_err();
    check(acc_err === 1'b0, "R10 cleared", 32'(acc_err), 32'h0);

    // R7: single wrong word in the last lane after reset
    do_reset();
    load_key(0); put_word(NUM_KEYS, good[NUM_KEYS-1] ^ 16'h0001);
    fire(); step(NUM_KEYS + 2);
    check(acc_err === 1'b1 && secured === 1'b1, "R7 last word", {30'd0, acc_err, secured}, 32'h3);
    // reset clears lockout, correct key then unlocks
    do_reset(); load_key(0); fire(); step(NUM_KEYS + 2);
    check(secured === 1'b0 && acc_err === 1'b0, "R5 unlock after reset", {30'd0, secured, acc_err}, 32'h0);

    step(2);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule